// File: doc/BRIEF.md
# Receive Pad Byte Stripper

This block sits in a receive byte stream behind an Ethernet MAC, after the frame check sequence has been removed. It trims the fill bytes that a sender appends to reach the minimum frame size. It reads the two-byte length/type word. If that word is a length, only the header and the stated number of payload bytes are forwarded. If it is a type, the frame normally goes through untouched. The exception is an IPv4 frame while the IP trim option is enabled. In that case the datagram total length from the IP header decides how many bytes are kept.

Trimmed bytes are suppressed. The final kept byte is held back until the real end of the input frame arrives, and it then leaves with the end marker and the frame's error flag. When a decoded length promises more bytes than the frame actually holds, the frame is forwarded whole and flagged as errored. Every other byte leaves exactly one cycle after it enters. The input has no backpressure.

Top module: `pad_strip_rx`

## Requirements
- R1: While reset is low and in the idle cycles after it, `out_valid`, `out_last` and `out_err` are 0.
- R2: When the big-endian word at byte positions 12–13 (position 0 is the first byte) is 1500 or less, the output frame is the first 14+word bytes of the input frame.
- R3: When that word is 0x0600 or more and no IP trim applies, the output frame equals the input frame.
- R4: When that word is between 1501 and 0x05FF, the output frame equals the input frame.
- R5: IP trim applies when all of these hold: `ip_strip_en` was 1 on the first byte, the word is 0x0800, the upper nibble of byte 14 is 4, and the big-endian total length TL at bytes 16–17 is 20 or more. The output is then the first 14+TL bytes.
- R6: A type frame that misses any one of the R5 conditions (version nibble, type value, or TL below 20) passes unchanged.
- R7: When R2 or R5 calls for more bytes than the frame holds, the frame passes whole and `out_err` is 1 on its last byte.
- R8: `in_err` on the input's last byte appears as `out_err` on the output's last byte, including for trimmed frames. `out_err` is 0 on every other output byte.
- R9: `ip_strip_en` is taken on the first byte of a frame. Changing it later in the same frame has no effect on that frame.
- R10: Each output byte appears one cycle after its input byte. The exception is the final kept byte of a trimmed frame, which appears one cycle after the input frame's last byte.
- R11: Each output frame carries exactly one `out_last`, on its final byte. It follows every input last byte by one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ip_strip_en | input | 1 | Enables trimming of IPv4 frames by datagram length; taken on each frame's first byte |
| in_valid | input | 1 | Input byte present |
| in_data | input | 8 | Input byte |
| in_last | input | 1 | Input byte is the last of its frame |
| in_err | input | 1 | Frame error, meaningful with `in_last` |
| out_valid | output | 1 | Output byte present |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Output byte ends the frame |
| out_err | output | 1 | Output frame is errored (upstream error or short frame), valid with `out_last` |

## Verification
A corrupted byte position counter or a stale header capture shows up as the wrong end marker: a frame cut short or left padded, visible within the same frame. A drop state that failed to clear would swallow the next frame's header, which breaks the one-cycle pass-through of the first bytes on the very next frame. A trim decision carried across frames would surface as a false short-frame error on the following frame's last byte. The sweeps cover every small length with exact, padded and short bodies, and IP totals with and without the option.

// File: rtl/pad_strip_pkg.sv
// Package: shared constants and the byte beat type for the pad stripper.
// Assumes frames start with a 14-byte Ethernet header without VLAN tag.
package pad_strip_pkg;

    // Byte positions within a frame, counted from 0.
    localparam int LT_HI_POS  = 12;
    localparam int LT_LO_POS  = 13;
    localparam int IP_VER_POS = 14;
    localparam int IP_TL_HI   = 16;
    localparam int IP_TL_LO   = 17;

    localparam logic [15:0] MAX_LEN_FIELD = 16'd1500;
    localparam logic [15:0] ETYPE_IPV4    = 16'h0800;
    localparam logic [15:0] IP_MIN_TOTAL  = 16'd20;
    localparam logic [3:0]  IP_VERSION4   = 4'd4;

    // One stream byte with its framing flags.
    typedef struct packed {
        logic [7:0] data;
        logic       last;
        logic       err;
    } beat_t;

endpackage

// File: rtl/pad_strip_pos.sv
// Module: byte position counter for the incoming frame.
// Gives the position of the byte currently on the input, 0 for the first byte.
// Assumes in_last only arrives together with in_valid; saturates on long frames.
module pad_strip_pos #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_last,
    output logic [CNT_W-1:0] pos
);
    localparam logic [CNT_W-1:0] POS_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] pos_q;

    // Advance per accepted byte, return to 0 after a last byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q <= '0;
        end else if (in_valid) begin
            if (in_last)
                pos_q <= '0;
            else if (pos_q != POS_MAX)
                pos_q <= pos_q + 1'b1;
        end
    end

    assign pos = pos_q;
endmodule

// File: rtl/pad_strip_hdr.sv
// Module: header field capture and trim decision.
// Captures the length/type word, IP version nibble and IP total length as they
// pass, and decides whether the frame is trimmed and at which byte position the
// kept part ends (cut). The decision is visible combinationally on the byte that
// completes it (position 13 or 17) and registered for the rest of the frame.
// Assumes CNT_W >= 16 so every cut position fits.
module pad_strip_hdr
    import pad_strip_pkg::*;
#(
    parameter int CNT_W = 16,
    localparam int CUT_W = CNT_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    input  logic             in_last,
    input  logic [CNT_W-1:0] pos,
    input  logic             ip_strip_en,
    output logic             trim_cur,
    output logic [CUT_W-1:0] cut_cur
);
    logic [7:0]       lt_hi_q;
    logic [7:0]       tl_hi_q;
    logic             is_ip_q;
    logic             ver4_q;
    logic             en_q;
    logic             trim_q;
    logic [CUT_W-1:0] cut_q;

    logic [15:0]      lt_now;
    logic [15:0]      tl_now;
    logic             len_hit;
    logic             ip_hit;
    logic [CUT_W-1:0] cut_now;

    // Combine the stored high byte with the byte on the input.
    always_comb begin
        lt_now  = {lt_hi_q, in_data};
        tl_now  = {tl_hi_q, in_data};
        len_hit = in_valid && (pos == CNT_W'(LT_LO_POS)) && (lt_now <= MAX_LEN_FIELD);
        ip_hit  = in_valid && (pos == CNT_W'(IP_TL_LO)) && en_q && is_ip_q && ver4_q
                  && (tl_now >= IP_MIN_TOTAL);
        cut_now = CUT_W'(LT_LO_POS) + CUT_W'(len_hit ? lt_now : tl_now);
    end

    // Present the decision for the current byte.
    always_comb begin
        trim_cur = trim_q || len_hit || ip_hit;
        cut_cur  = (len_hit || ip_hit) ? cut_now : cut_q;
    end

    // Capture header fields and hold the trim decision until frame end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lt_hi_q <= '0;
            tl_hi_q <= '0;
            is_ip_q <= 1'b0;
            ver4_q  <= 1'b0;
            en_q    <= 1'b0;
            trim_q  <= 1'b0;
            cut_q   <= '0;
        end else if (in_valid) begin
            if (pos == '0)
                en_q <= ip_strip_en;
            if (pos == CNT_W'(LT_HI_POS))
                lt_hi_q <= in_data;
            if (pos == CNT_W'(LT_LO_POS))
                is_ip_q <= (lt_now == ETYPE_IPV4);
            if (pos == CNT_W'(IP_VER_POS))
                ver4_q <= (in_data[7:4] == IP_VERSION4);
            if (pos == CNT_W'(IP_TL_HI))
                tl_hi_q <= in_data;
            if (in_last) begin
                trim_q <= 1'b0;
            end else if (len_hit || ip_hit) begin
                trim_q <= 1'b1;
                cut_q  <= cut_now;
            end
        end
    end
endmodule

// File: rtl/pad_strip_emit.sv
// Module: output stage of the pad stripper.
// Forwards kept bytes one cycle late. The byte at the cut position of a frame
// that continues is parked in the output register, the bytes after it are
// dropped, and the parked byte leaves when the input last byte arrives,
// carrying that byte's error flag. A trimmed frame that ends before the cut
// is passed whole with its error flag forced.
module pad_strip_emit
    import pad_strip_pkg::*;
#(
    parameter int CNT_W = 16,
    localparam int CUT_W = CNT_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  beat_t            in_beat,
    input  logic [CNT_W-1:0] pos,
    input  logic             trim_cur,
    input  logic [CUT_W-1:0] cut_cur,
    output logic             out_valid,
    output beat_t            out_beat
);
    logic  ov_q;
    logic  drop_q;
    beat_t ob_q;
    logic  at_cut;

    // The current byte is the final one to keep.
    always_comb at_cut = trim_cur && (CUT_W'(pos) == cut_cur);

    // Forward, park or drop each byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ov_q   <= 1'b0;
            drop_q <= 1'b0;
            ob_q   <= '0;
        end else begin
            ov_q <= 1'b0;
            if (in_valid) begin
                if (drop_q) begin
                    if (in_beat.last) begin
                        ov_q      <= 1'b1;
                        ob_q.last <= 1'b1;
                        ob_q.err  <= in_beat.err;
                        drop_q    <= 1'b0;
                    end
                end else if (at_cut) begin
                    ob_q.data <= in_beat.data;
                    ob_q.last <= in_beat.last;
                    ob_q.err  <= in_beat.err;
                    if (in_beat.last)
                        ov_q <= 1'b1;
                    else
                        drop_q <= 1'b1;
                end else begin
                    ov_q      <= 1'b1;
                    ob_q.data <= in_beat.data;
                    ob_q.last <= in_beat.last;
                    ob_q.err  <= in_beat.err || (in_beat.last && trim_cur);
                end
            end
        end
    end

    // Flags are only shown together with a valid byte.
    always_comb begin
        out_valid     = ov_q;
        out_beat.data = ob_q.data;
        out_beat.last = ov_q && ob_q.last;
        out_beat.err  = ov_q && ob_q.err;
    end
endmodule

// File: rtl/pad_strip_rx.sv
// Module: receive pad byte stripper, top level.
// Removes Ethernet fill bytes using the length field, or optionally the IPv4
// total length for IPv4 type frames. Byte stream in and out, no backpressure.
// Assumes the frame check sequence is already removed and there is no VLAN tag.
module pad_strip_rx
    import pad_strip_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ip_strip_en,
    input  logic       in_valid,
    input  logic [7:0] in_data,
    input  logic       in_last,
    input  logic       in_err,
    output logic       out_valid,
    output logic [7:0] out_data,
    output logic       out_last,
    output logic       out_err
);
    localparam int CUT_W = CNT_W + 1;

    logic [CNT_W-1:0] pos_idx;
    logic             trim_cur;
    logic [CUT_W-1:0] cut_cur;
    beat_t            in_beat;
    beat_t            out_beat;

    // Bundle the input flags into one beat.
    always_comb begin
        in_beat.data = in_data;
        in_beat.last = in_last;
        in_beat.err  = in_err;
    end

    pad_strip_pos #(.CNT_W(CNT_W)) u_pos (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_last  (in_last),
        .pos      (pos_idx)
    );

    pad_strip_hdr #(.CNT_W(CNT_W)) u_hdr (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_data     (in_data),
        .in_last     (in_last),
        .pos         (pos_idx),
        .ip_strip_en (ip_strip_en),
        .trim_cur    (trim_cur),
        .cut_cur     (cut_cur)
    );

    pad_strip_emit #(.CNT_W(CNT_W)) u_emit (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_beat  (in_beat),
        .pos      (pos_idx),
        .trim_cur (trim_cur),
        .cut_cur  (cut_cur),
        .out_valid(out_valid),
        .out_beat (out_beat)
    );

    // Unbundle the output beat.
    always_comb begin
        out_data = out_beat.data;
        out_last = out_beat.last;
        out_err  = out_beat.err;
    end
endmodule

// File: rtl/pad_strip_rx_chk.sv
// Module: property checker for pad_strip_rx, attached by bind.
// Relates the input and output streams over one cycle; uses the byte position
// from the counter to check header pass-through.
module pad_strip_rx_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [7:0]       in_data,
    input logic             in_last,
    input logic             in_err,
    input logic             out_valid,
    input logic [7:0]       out_data,
    input logic             out_last,
    input logic             out_err,
    input logic [CNT_W-1:0] pos_idx
);
    // R10: no output byte without an input byte one cycle earlier.
    a_r10_no_idle_out: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(in_valid) |-> !out_valid);

    // R10: header bytes before the length/type decision pass one cycle later.
    a_r10_hdr_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (pos_idx < CNT_W'(13))) |=> (out_valid && (out_data == $past(in_data))));

    // R11: every input last byte closes an output frame one cycle later.
    a_r11_close_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_last) |=> (out_valid && out_last));

    // R11: an output last only follows an input last.
    a_r11_last_source: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> $past(in_valid && in_last));

    // R8: an upstream error reaches the output frame end.
    a_r8_err_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_last && in_err) |=> out_err);
endmodule

bind pad_strip_rx pad_strip_rx_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .in_last   (in_last),
    .in_err    (in_err),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_last  (out_last),
    .out_err   (out_err),
    .pos_idx   (pos_idx)
);

// File: tb/pad_strip_rx_tb.sv
// Bench: sweeps length values, IP total lengths, body sizes and option
// settings, computing the kept byte count and timing arithmetically.
module pad_strip_rx_tb;
    localparam int WD_LIMIT = 190000;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       ip_strip_en;
    logic       in_valid;
    logic [7:0] in_data;
    logic       in_last;
    logic       in_err;
    logic       out_valid;
    logic [7:0] out_data;
    logic       out_last;
    logic       out_err;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int gn = 0;
    bit done = 0;

    logic [7:0] frm   [0:2047];
    int         in_cyc[0:2047];
    logic [7:0] got_d [0:2047];
    logic       got_l [0:2047];
    logic       got_e [0:2047];
    int         got_c [0:2047];

    pad_strip_rx u_dut (
        .clk(clk), .rst_n(rst_n), .ip_strip_en(ip_strip_en),
        .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_err(in_err),
        .out_valid(out_valid), .out_data(out_data), .out_last(out_last), .out_err(out_err)
    );

    always #4 clk = ~clk;   // 125 MHz

    always @(posedge clk) cyc <= cyc + 1;

    // Capture output bytes away from the active edge.
    always @(negedge clk) begin
        if (out_valid && gn < 2048) begin
            got_d[gn] = out_data;
            got_l[gn] = out_last;
            got_e[gn] = out_err;
            got_c[gn] = cyc;
            gn = gn + 1;
        end
    end

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        if (cyc > WD_LIMIT && !done) begin
            done = 1;
            bad = bad + 1;
            total = total + 1;
            $display("FAIL watchdog: actual cycles=%0d expected below %0d", cyc, WD_LIMIT);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic note(input bit ok, input string req, input string what, input int act, input int exp);
        total = total + 1;
        if (!ok) begin
            bad = bad + 1;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic fill(input int n, input int seed);
        for (int i = 0; i < 2048; i++) frm[i] = 8'((i * 37 + seed * 11 + 5) & 255);
        if (n < 0) $display("bad fill size");
    endtask

    task automatic set_lt(input int v);
        frm[12] = 8'(v >> 8);
        frm[13] = 8'(v);
    endtask

    task automatic set_ip(input int ver, input int tl);
        set_lt(16'h0800);
        frm[14] = 8'((ver << 4) | 5);
        frm[16] = 8'(tl >> 8);
        frm[17] = 8'(tl);
    endtask

    // Drive one frame, then check content, end marker, error and timing.
    task automatic run_frame(input string tag, input int n, input bit en0, input bit flip, input bit ierr);
        int lt, tl, kcut, keep, mism, lbad, ebad, tbad, ecyc;
        bit trim, short_f, experr;
        lt = {frm[12], frm[13]};
        tl = {frm[16], frm[17]};
        trim = 0;
        kcut = n;
        if (n >= 14 && lt <= 1500) begin
            trim = 1; kcut = 14 + lt;
        end else if (en0 && n >= 18 && lt == 16'h0800 && frm[14][7:4] == 4'd4 && tl >= 20) begin
            trim = 1; kcut = 14 + tl;
        end
        short_f = trim && (kcut > n);
        keep = (trim && !short_f) ? kcut : n;
        experr = ierr || short_f;

        gn = 0;
        for (int k = 0; k < n; k++) begin
            if (((k * 7 + n) % 5) == 0) begin
                @(negedge clk);
                in_valid = 0; in_last = 0; in_err = 0;
            end
            @(negedge clk);
            in_valid = 1;
            in_data  = frm[k];
            in_last  = (k == n - 1);
            in_err   = ierr && (k == n - 1);
            if (k == 0) ip_strip_en = en0;
            else if (flip && k == 5) ip_strip_en = !en0;
            in_cyc[k] = cyc;
        end
        @(negedge clk);
        in_valid = 0; in_last = 0; in_err = 0;
        repeat (3) @(negedge clk);

        mism = 0; lbad = 0; ebad = 0; tbad = 0;
        for (int i = 0; i < keep && i < gn; i++) begin
            if (got_d[i] !== frm[i]) mism++;
            if (got_l[i] !== (i == keep - 1)) lbad++;
            if (i < keep - 1 && got_e[i] !== 1'b0) ebad++;
            ecyc = (i == keep - 1 && keep < n) ? in_cyc[n - 1] + 1 : in_cyc[i] + 1;
            if (got_c[i] != ecyc) tbad++;
        end
        note(gn == keep && mism == 0, tag, "kept byte count", gn, keep);
        note(gn == keep && lbad == 0, "R11", "misplaced end markers", lbad, 0);
        if (gn > 0)
            note(ebad == 0 && got_e[gn - 1] === experr, short_f ? "R7" : "R8",
                 "error on last byte", int'(got_e[gn - 1]), int'(experr));
        else
            note(0, "R8", "no output frame", 0, 1);
        note(tbad == 0, "R10", "bytes off their cycle", tbad, 0);
    endtask

    initial begin
        rst_n = 0; ip_strip_en = 0; in_valid = 0; in_data = 0; in_last = 0; in_err = 0;
        repeat (5) begin
            @(negedge clk);
            note(!out_valid && !out_last && !out_err, "R1", "output in reset", int'(out_valid), 0);
        end
        rst_n = 1;
        repeat (3) begin
            @(negedge clk);
            note(!out_valid && !out_last && !out_err, "R1", "output idle after reset", int'(out_valid), 0);
        end

        // R2: every small length with exact, one-over, padded and short bodies.
        for (int ln = 0; ln < 64; ln++) begin
            for (int v = 0; v < 4; v++) begin
                int n;
                if (v == 0) n = 14 + ln;
                else if (v == 1) n = 15 + ln;
                else if (v == 2) n = (14 + ln < 60) ? 60 : 14 + ln + 2;
                else n = 13 + ln;
                fill(n, ln * 4 + v);
                set_lt(ln);
                run_frame("R2", n, ln[0], 1'b0, ((ln + v) % 3) == 0);
            end
        end

        // R2/R7: the largest length value.
        fill(1514, 1); set_lt(1500); run_frame("R2", 1514, 1'b0, 1'b0, 1'b0);
        fill(1520, 2); set_lt(1500); run_frame("R2", 1520, 1'b1, 1'b0, 1'b1);
        fill(200, 3);  set_lt(1500); run_frame("R7", 200, 1'b0, 1'b0, 1'b0);

        // R4: values between length and type range pass untrimmed.
        fill(60, 4); set_lt(1501);    run_frame("R4", 60, 1'b1, 1'b0, 1'b0);
        fill(64, 5); set_lt(16'h05FF); run_frame("R4", 64, 1'b0, 1'b0, 1'b1);
        fill(60, 6); set_lt(1535);    run_frame("R4", 60, 1'b0, 1'b0, 1'b0);

        // R3: type values, including IPv4 with the option off.
        fill(60, 7); set_lt(16'h0600); run_frame("R3", 60, 1'b1, 1'b0, 1'b0);
        fill(60, 8); set_lt(16'h86DD); run_frame("R3", 60, 1'b1, 1'b0, 1'b0);

        // R5/R3/R9: IPv4 total lengths with and without the option.
        for (int en = 0; en < 2; en++) begin
            for (int tl = 20; tl <= 46; tl++) begin
                for (int p = 0; p < 3; p++) begin
                    int n;
                    bit flip;
                    n = 14 + tl + ((p == 0) ? 0 : (p == 1) ? 2 : 9);
                    flip = (tl % 4) == 0;
                    fill(n, tl * 3 + p + en);
                    set_ip(4, tl);
                    run_frame(flip ? "R9" : (en != 0 ? "R5" : "R3"), n, en[0], flip, (tl % 5) == 0);
                end
            end
        end

        // R6: IP trim conditions not met.
        fill(60, 9);  set_ip(6, 30); run_frame("R6", 60, 1'b1, 1'b0, 1'b0);
        fill(60, 10); set_ip(4, 30); set_lt(16'h0806); run_frame("R6", 60, 1'b1, 1'b0, 1'b0);
        fill(60, 11); set_ip(4, 19); run_frame("R6", 60, 1'b1, 1'b0, 1'b0);

        // R7: IP total length beyond the frame.
        fill(60, 12); set_ip(4, 200); run_frame("R7", 60, 1'b1, 1'b0, 1'b0);
        fill(18, 13); set_ip(4, 20);  run_frame("R7", 18, 1'b1, 1'b0, 1'b1);

        // R9: option raised mid-frame has no effect.
        fill(60, 14); set_ip(4, 28); run_frame("R9", 60, 1'b0, 1'b1, 1'b0);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule